// File: doc/BRIEF.md
# GPIO Port with Standby Pin Control

An eight-pin general-purpose I/O port. Each pin is driven either from a port data register or, when that pin's peripheral-enable input is high, from a peripheral's output and output-enable. A direction register selects drive or receive for pins the port owns. Each incoming pin value passes through a two-flop synchronizer before it reaches the core, and the core sees it on the `coreIn` bus.

A standby controller outside the block reports the power mode on a two-bit code and provides a pin-state bit. In the two deep standby modes, with that bit set, every pin is released to high impedance whatever the direction register holds. The input seen by the core is also clamped low, so floating pads cause no leakage or toggling. With the bit clear, pins keep working as in normal operation.

Pins handed to an LCD driver are never driven by the port. A separate input-control bit blocks their digital input. A one-bit input-level choice is held as a readable register only.

Top module: `gpio_standby_port`

## Requirements
- R1: While reset is low, `padOe` is 0 even if peripherals request drive, and `coreIn` is 0. After reset, the data, direction, LCD and level registers all read 0.
- R2: The register offsets are fixed. Offset 0 is data, offset 1 is direction, offset 2 is LCD assignment (1 = pin belongs to the LCD) and offset 3 is the level register. A write with `busSel` and `busWr` high takes effect at the clock edge. `busRdata` is combinational from `busAddr`.
- R3: In power modes 00 (normal) and 01 (sleep), a pin with `periphEn` low has `padOe` equal to its direction bit and `padOut` equal to its data bit.
- R4: A pin with `periphEn` high takes `padOe` from `periphOe` and `padOut` from `periphOut`.
- R5: In modes 10 (stop) and 11 (watch) with `pinStateBit` = 1, `padOe` is all 0 in the same cycle, whatever the direction, data and peripheral inputs are.
- R6: Under the same condition as R5, `coreIn` is 0 in the same cycle, and reading offset 0 returns 0 for receive pins.
- R7: In modes 10 and 11 with `pinStateBit` = 0, `padOe` and `padOut` keep the values they had in normal mode, and `coreIn` keeps following the pads.
- R8: Register contents are kept through every standby mode. On return to mode 00, the pins drive their earlier values again.
- R9: A change on `padIn` appears on `coreIn` after exactly two rising clock edges.
- R10: Reading offset 0 returns the latched data bit for pins whose direction bit is 1, and the `coreIn` bit for pins whose direction bit is 0.
- R11: A pin whose LCD bit is 1 has `padOe` 0 and `padOut` 0, even when its direction bit is 1 or a peripheral drives it. Its `coreIn` bit is 0 while `lcdInputCut` is 1, and follows the pad while `lcdInputCut` is 0.
- R12: The level register keeps only bit 5, which resets to 0. The other bits of offset 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe |
| busAddr | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| pwrMode | input | 2 | 00 normal, 01 sleep, 10 stop, 11 watch |
| pinStateBit | input | 1 | Release pins in stop/watch when 1 |
| lcdInputCut | input | 1 | Block digital input on LCD pins |
| periphEn | input | 8 | Per-pin peripheral ownership |
| periphOut | input | 8 | Peripheral output values |
| periphOe | input | 8 | Peripheral output enables |
| padIn | input | 8 | Pad input values |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| coreIn | output | 8 | Synchronized, gated input to the core |

## Verification
The hardest case is the standby entry where `pinStateBit` is 0. There the outputs must not move even though the mode code changes. The stimulus sets up mixed port and peripheral ownership and then steps through stop and watch with the bit at 0. It also steps through both modes with the bit at 1, comparing the pin outputs in each case. The synchronizer delay is measured edge by edge. The input cutoff is then applied on top of a value already synchronized, so that the clamp can be told apart from the pipeline delay.

// File: rtl/gpio_sp_pkg.sv
package gpio_sp_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_SLEEP  = 2'b01,
    PM_STOP   = 2'b10,
    PM_WATCH  = 2'b11
  } pwr_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA = 2'd0,
    RA_DIR  = 2'd1,
    RA_LCD  = 2'd2,
    RA_LVL  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic      wrData;
    logic      wrDir;
    logic      wrLcd;
    logic      wrLvl;
    logic      standbyCut;
    reg_addr_e rdSel;
  } ctrl_strb_t;
endpackage

// File: rtl/gpio_sp_ctrl.sv
module gpio_sp_ctrl
  import gpio_sp_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        pwrMode,
  input  logic              pinStateBit,
  output ctrl_strb_t        strb
);
  logic      wrHit;
  pwr_mode_e mode;
  reg_addr_e addr;

  assign wrHit = busSel & busWr;
  assign mode  = pwr_mode_e'(pwrMode);
  assign addr  = reg_addr_e'(busAddr);

  always_comb begin
    strb.wrData     = wrHit && (addr == RA_DATA);
    strb.wrDir      = wrHit && (addr == RA_DIR);
    strb.wrLcd      = wrHit && (addr == RA_LCD);
    strb.wrLvl      = wrHit && (addr == RA_LVL);
    strb.standbyCut = pinStateBit && ((mode == PM_STOP) || (mode == PM_WATCH));
    strb.rdSel      = addr;
  end
endmodule

// File: rtl/gpio_sp_datapath.sv
module gpio_sp_datapath
  import gpio_sp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_BIT     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic [WIDTH-1:0] wdata,
  input  logic             lcdInCut,
  input  logic [WIDTH-1:0] periphEn,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] periphOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] coreIn,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] dataReg, dirReg, lcdReg;
  logic             lvlReg;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] syncOut;
  logic [WIDTH-1:0] dataView;

  // software-visible registers; nothing here looks at the power mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      lcdReg  <= '0;
      lvlReg  <= 1'b0;
    end else begin
      if (strb.wrData) dataReg <= wdata;
      if (strb.wrDir)  dirReg  <= wdata;
      if (strb.wrLcd)  lcdReg  <= wdata;
      if (strb.wrLvl)  lvlReg  <= wdata[LVL_BIT];
    end
  end

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic selOe, selOut, inBlock;
    assign selOe     = periphEn[i] ? periphOe[i]  : dirReg[i];
    assign selOut    = periphEn[i] ? periphOut[i] : dataReg[i];
    assign inBlock   = strb.standbyCut | (lcdReg[i] & lcdInCut);
    assign padOe[i]  = rstN & ~strb.standbyCut & ~lcdReg[i] & selOe;
    assign padOut[i] = ~lcdReg[i] & selOut;
    assign coreIn[i] = ~inBlock & syncOut[i];
    assign dataView[i] = dirReg[i] ? dataReg[i] : coreIn[i];
  end

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      RA_DATA: rdata = dataView;
      RA_DIR:  rdata = dirReg;
      RA_LCD:  rdata = lcdReg;
      RA_LVL:  rdata[LVL_BIT] = lvlReg;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
  import gpio_sp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_BIT     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [1:0]        pwrMode,
  input  logic              pinStateBit,
  input  logic              lcdInputCut,
  input  logic [WIDTH-1:0]  periphEn,
  input  logic [WIDTH-1:0]  periphOut,
  input  logic [WIDTH-1:0]  periphOe,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  coreIn
);
  ctrl_strb_t strb;

  gpio_sp_ctrl u_ctrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .pwrMode     (pwrMode),
    .pinStateBit (pinStateBit),
    .strb        (strb)
  );

  gpio_sp_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES),
    .LVL_BIT     (LVL_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .lcdInCut  (lcdInputCut),
    .periphEn  (periphEn),
    .periphOut (periphOut),
    .periphOe  (periphOe),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .coreIn    (coreIn),
    .rdata     (busRdata)
  );
endmodule

// File: rtl/gpio_sp_checker.sv
module gpio_sp_checker #(
  parameter int WIDTH   = 8,
  parameter int LVL_BIT = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [WIDTH-1:0] busRdata,
  input logic [1:0]       pwrMode,
  input logic             pinStateBit,
  input logic [WIDTH-1:0] periphEn,
  input logic [WIDTH-1:0] periphOut,
  input logic [WIDTH-1:0] periphOe,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] coreIn
);
  localparam logic [WIDTH-1:0] LVL_MASK = WIDTH'(1) << LVL_BIT;

  always_comb begin
    if (!rstN) begin
      a_r1_reset_released: assert (padOe == '0 && coreIn == '0);
    end
  end

  a_r5_standby_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode[1] && pinStateBit) |-> (padOe == '0));

  a_r6_standby_input_low: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode[1] && pinStateBit) |-> (coreIn == '0));

  a_r7_keep_outputs: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$stable(pwrMode) && !pinStateBit && !$past(pinStateBit)
     && $stable(periphEn) && $stable(periphOut) && $stable(periphOe)
     && !$past(busSel && busWr))
    |-> ($stable(padOe) && $stable(padOut)));

  a_r12_level_only_bit: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> ((busRdata & ~LVL_MASK) == '0));
endmodule

bind gpio_standby_port gpio_sp_checker #(.WIDTH(WIDTH), .LVL_BIT(LVL_BIT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busRdata    (busRdata),
  .pwrMode     (pwrMode),
  .pinStateBit (pinStateBit),
  .periphEn    (periphEn),
  .periphOut   (periphOut),
  .periphOe    (periphOe),
  .padOut      (padOut),
  .padOe       (padOe),
  .coreIn      (coreIn)
);

// File: tb/gpio_standby_port_bench.sv
`timescale 1ns/1ps
module gpio_standby_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [1:0] pwrMode = '0;
  logic       pinStateBit = 1'b0, lcdInputCut = 1'b0;
  logic [7:0] periphEn = '0, periphOut = '0, periphOe = '0, padIn = '0;
  logic [7:0] padOut, padOe, coreIn;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_standby_port u_gpio_standby_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwrMode(pwrMode),
    .pinStateBit(pinStateBit), .lcdInputCut(lcdInputCut), .periphEn(periphEn),
    .periphOut(periphOut), .periphOe(periphOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .coreIn(coreIn)
  );

  typedef struct packed {
    logic [7:0] dir, data, pEn, pOut, pOe;
    logic [1:0] mode;
    logic       spl;
    logic [7:0] expOe, expOut;
  } vec_t;

  // R3/R4 mux, R5 release, R7 hold, across mixed ownership
  localparam vec_t VECS [8] = '{
    {8'hF0, 8'hA5, 8'h00, 8'h00, 8'h00, 2'b00, 1'b0, 8'hF0, 8'hA5},
    {8'hF0, 8'hA5, 8'h00, 8'h00, 8'h00, 2'b01, 1'b1, 8'hF0, 8'hA5},
    {8'hFF, 8'h3C, 8'h0F, 8'h06, 8'h05, 2'b00, 1'b0, 8'hF5, 8'h36},
    {8'hFF, 8'h3C, 8'h0F, 8'h06, 8'h05, 2'b10, 1'b1, 8'h00, 8'h36},
    {8'hFF, 8'h3C, 8'h0F, 8'h06, 8'h05, 2'b11, 1'b1, 8'h00, 8'h36},
    {8'hFF, 8'h3C, 8'h0F, 8'h06, 8'h05, 2'b10, 1'b0, 8'hF5, 8'h36},
    {8'hFF, 8'h3C, 8'h0F, 8'h06, 8'h05, 2'b11, 1'b0, 8'hF5, 8'h36},
    {8'h0F, 8'h81, 8'hF0, 8'hAA, 8'hC3, 2'b00, 1'b1, 8'hCF, 8'hA1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busSel = 1'b1;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    // R1: reset with peripherals requesting drive
    periphEn = 8'hFF; periphOe = 8'hFF; padIn = 8'hFF;
    repeat (3) @(negedge clk);
    #1 check("R1 oe in reset", padOe, 8'h00);
    check("R1 coreIn in reset", coreIn, 8'h00);
    periphEn = '0; periphOe = '0; padIn = '0;
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), rd);
      check("R1 register reset value", rd, 8'h00);
    end

    // table walk
    for (int v = 0; v < 8; v++) begin
      busWrite(2'd1, VECS[v].dir);
      busWrite(2'd0, VECS[v].data);
      @(negedge clk);
      periphEn = VECS[v].pEn; periphOut = VECS[v].pOut; periphOe = VECS[v].pOe;
      pwrMode = VECS[v].mode; pinStateBit = VECS[v].spl;
      #1 check("R3/R4/R5/R7 padOe", padOe, VECS[v].expOe);
      check("R3/R4/R5/R7 padOut", padOut, VECS[v].expOut);
    end

    // R9: synchronizer delay
    @(negedge clk);
    periphEn = '0; periphOut = '0; periphOe = '0; pwrMode = 2'b00; pinStateBit = 1'b0;
    busWrite(2'd1, 8'h00);
    @(negedge clk) padIn = 8'h5A;
    @(negedge clk); #1 check("R9 one edge", coreIn, 8'h00);
    @(negedge clk); #1 check("R9 two edges", coreIn, 8'h5A);

    // R6: input clamp in stop with pin-state bit set
    @(negedge clk) begin pwrMode = 2'b10; pinStateBit = 1'b1; end
    #1 check("R6 coreIn clamp", coreIn, 8'h00);
    busRead(2'd0, rd);
    check("R6 data read clamped", rd, 8'h00);
    @(negedge clk) pinStateBit = 1'b0;
    #1 check("R7 coreIn follows", coreIn, 8'h5A);
    @(negedge clk) pwrMode = 2'b00;

    // R10: mixed read of data offset
    busWrite(2'd1, 8'h0F);
    busWrite(2'd0, 8'h33);
    busRead(2'd0, rd);
    check("R10 mixed data read", rd, 8'h53);

    // R8: retention through watch with release
    busWrite(2'd1, 8'hFF);
    busWrite(2'd0, 8'hC3);
    @(negedge clk) begin pwrMode = 2'b11; pinStateBit = 1'b1; end
    #1 check("R5 watch release", padOe, 8'h00);
    repeat (4) @(negedge clk);
    pwrMode = 2'b00;
    #1 check("R8 oe restored", padOe, 8'hFF);
    check("R8 out restored", padOut, 8'hC3);
    busRead(2'd1, rd);
    check("R8 dir kept", rd, 8'hFF);
    @(negedge clk) pinStateBit = 1'b0;

    // R11: LCD pins
    busWrite(2'd2, 8'h81);
    @(negedge clk) begin periphEn = 8'h01; periphOe = 8'h01; periphOut = 8'h01; end
    #1 check("R11 lcd oe", padOe, 8'h7E);
    check("R11 lcd out", padOut, 8'h42);
    padIn = 8'hFF; lcdInputCut = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R11 lcd input cut", coreIn, 8'h7E);
    lcdInputCut = 1'b0;
    #1 check("R11 lcd input open", coreIn, 8'hFF);
    busRead(2'd2, rd);
    check("R2 lcd offset", rd, 8'h81);

    // R12: level register
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, rd);
    check("R12 level bit only", rd, 8'h20);
    busWrite(2'd3, 8'hDF);
    busRead(2'd3, rd);
    check("R12 level cleared", rd, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule